// File: doc/BRIEF.md
# One-Shot Serial Configuration Loader

This block holds the digital configuration for a ten-output clock fan-out. A configuration word of eleven bits arrives one bit per rising edge of a slow shift clock, on a single serial pin, while a mode pin is held high. One further edge commits the word to a control register. That register then drives ten per-output enable lines and a single select line that picks one of two input clocks. After the commit the register is frozen until the block is re-armed. A shift-clock edge taken with the mode pin low re-arms it.

With the mode pin low the block is bypassed. All ten enables are asserted and the serial pin itself chooses the input clock. The stored state is ignored.

The buffers and the clock multiplexer live elsewhere. This block only produces their enable and select levels.

Top module: `serial_cfg_loader`

## Requirements
- R1: On each rising `clk` edge with `cfg_en` high and fewer than 11 shifts taken since re-arm, the first shift stage takes `ser_in` and every other stage takes the previous stage. The first bit sent becomes configuration bit D0 and the eleventh becomes D10.
- R2: The control register loads the shifted word only on the 12th consecutive `cfg_en`-high edge after re-arm. After only 11 such edges the outputs still show the unloaded state.
- R3: Once loaded, further edges with `cfg_en` high change neither the control register nor the outputs, whatever `ser_in` does.
- R4: A rising `clk` edge with `cfg_en` low clears the shift counter, the shift stages and the control register. A complete new 12-edge sequence is then needed to load again, and a partial earlier sequence leaves no trace.
- R5: With `cfg_en` high, configuration bit Dn (n = 0..9) drives `out_en[9-n]`, and a low bit disables that output. D10 drives `clk_sel`, where 0 selects input clock 0 and 1 selects input clock 1.
- R6: With `cfg_en` low, `out_en` is all ones and `clk_sel` equals `ser_in`, combinationally and regardless of the stored state.
- R7: With `cfg_en` high after re-arm and before a load, `out_en` is all zeros and `clk_sel` is 0.
- R8: While `rst_n` is low, all state is cleared asynchronously.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low power-on clear |
| cfg_en | input | 1 | High: programmed mode (shift/commit); low: bypass and re-arm on each edge |
| ser_in | input | 1 | Serial configuration data; in bypass it is the clock select |
| out_en | output | 10 | Per-output enables, 1 = output running |
| clk_sel | output | 1 | Input clock select, 0 = clock 0, 1 = clock 1 |

## Verification
The bypass results (R6) follow `cfg_en` and `ser_in` within the same cycle and are checked 1 ns after inputs change, with no clock edge in between. Every stored effect (shift, commit, re-arm) appears after the single register stage it passes through. The bench therefore changes inputs on the falling edge and samples 1 ns after the following rising edge. At the 11th shift it confirms that nothing is visible yet, and it expects the loaded word exactly one edge later. The bench sweeps walking-one words over all eleven positions plus dense and sparse words. It predicts each output from the bit order stated in R1 and R5.

// File: rtl/cfgld_pkg.sv
`timescale 1ns/1ps
package cfgld_pkg;
  localparam int NUM_OUT = 10;
  localparam int CFG_W   = NUM_OUT + 1;
  localparam int CNT_W   = $clog2(CFG_W + 2);

  // Shift stages hold the first-sent bit furthest from the input.
  // Returns the word indexed by configuration bit number.
  function automatic logic [CFG_W-1:0] stages_to_dbits(input logic [CFG_W-1:0] st);
    logic [CFG_W-1:0] d;
    for (int i = 0; i < CFG_W; i++) d[i] = st[CFG_W-1-i];
    return d;
  endfunction

  // Configuration bit n enables output NUM_OUT-1-n.
  function automatic logic [NUM_OUT-1:0] dbits_to_enables(input logic [CFG_W-1:0] d);
    logic [NUM_OUT-1:0] e;
    for (int j = 0; j < NUM_OUT; j++) e[j] = d[NUM_OUT-1-j];
    return e;
  endfunction
endpackage

// File: rtl/cfgld_seq.sv
`timescale 1ns/1ps
module cfgld_seq
  import cfgld_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_en,
  output logic do_shift,
  output logic do_commit,
  output logic committed
);
  localparam logic [CNT_W-1:0] LOAD_CNT = CNT_W'(CFG_W);
  localparam logic [CNT_W-1:0] DONE_CNT = CNT_W'(CFG_W + 1);

  logic [CNT_W-1:0] cnt_q;

  assign do_shift  = cfg_en && (cnt_q < LOAD_CNT);
  assign do_commit = cfg_en && (cnt_q == LOAD_CNT);
  assign committed = (cnt_q == DONE_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!cfg_en)         cnt_q <= '0;
    else if (cnt_q != DONE_CNT) cnt_q <= cnt_q + 1'b1;
  end

  // R4
  seq_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (cnt_q == '0));
  // R3
  seq_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && committed) |=> committed);
  // R2
  seq_commit_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_commit |=> !do_commit);
  // R1
  seq_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_shift |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/cfgld_shreg.sv
`timescale 1ns/1ps
module cfgld_shreg
  import cfgld_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             do_shift,
  input  logic             ser_in,
  output logic [CFG_W-1:0] stages
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stages <= '0;
    else if (clr)      stages <= '0;
    else if (do_shift) stages <= {stages[CFG_W-2:0], ser_in};
  end

  // R1
  shreg_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_shift |=> (stages[0] == $past(ser_in)));
  // R1
  shreg_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_shift |=> (stages[CFG_W-1:1] == $past(stages[CFG_W-2:0])));
  // R4
  shreg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (stages == '0));
endmodule

// File: rtl/cfgld_ctrl.sv
`timescale 1ns/1ps
module cfgld_ctrl
  import cfgld_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             do_commit,
  input  logic             committed,
  input  logic [CFG_W-1:0] stages,
  output logic [CFG_W-1:0] dbits
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dbits <= '0;
    else if (clr)       dbits <= '0;
    else if (do_commit) dbits <= stages_to_dbits(stages);
  end

  // R2
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_commit |=> (dbits[0] == $past(stages[CFG_W-1]) && dbits[CFG_W-1] == $past(stages[0])));
  // R3
  ctrl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && committed) |=> $stable(dbits));
  // R7
  ctrl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !do_commit && !committed) |=> $stable(dbits));
  // R4
  ctrl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (dbits == '0));
endmodule

// File: rtl/cfgld_outsel.sv
`timescale 1ns/1ps
module cfgld_outsel
  import cfgld_pkg::*;
(
  input  logic               cfg_en,
  input  logic               ser_in,
  input  logic [CFG_W-1:0]   dbits,
  output logic [NUM_OUT-1:0] out_en,
  output logic               clk_sel
);
  always_comb begin
    if (cfg_en) begin
      out_en  = dbits_to_enables(dbits);
      clk_sel = dbits[CFG_W-1];
    end else begin
      out_en  = '1;
      clk_sel = ser_in;
    end
  end
endmodule

// File: rtl/serial_cfg_loader.sv
`timescale 1ns/1ps
module serial_cfg_loader
  import cfgld_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_en,
  input  logic               ser_in,
  output logic [NUM_OUT-1:0] out_en,
  output logic               clk_sel
);
  logic             do_shift;
  logic             do_commit;
  logic             committed;
  logic             rearm;
  logic [CFG_W-1:0] stages;
  logic [CFG_W-1:0] dbits;

  assign rearm = !cfg_en;

  cfgld_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en),
    .do_shift(do_shift), .do_commit(do_commit), .committed(committed)
  );

  cfgld_shreg u_shreg (
    .clk(clk), .rst_n(rst_n), .clr(rearm), .do_shift(do_shift),
    .ser_in(ser_in), .stages(stages)
  );

  cfgld_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .clr(rearm), .do_commit(do_commit),
    .committed(committed), .stages(stages), .dbits(dbits)
  );

  cfgld_outsel u_outsel (
    .cfg_en(cfg_en), .ser_in(ser_in), .dbits(dbits),
    .out_en(out_en), .clk_sel(clk_sel)
  );

  // R6
  always_comb begin
    if (rst_n && !cfg_en) begin
      bypass_chk: assert (out_en == '1 && clk_sel == ser_in);
    end
  end

  // R5
  top_sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && committed) |=> (!cfg_en || $stable(clk_sel)));
endmodule

// File: tb/serial_cfg_loader_tb.sv
`timescale 1ns/1ps
module serial_cfg_loader_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_en = 1'b0;
  logic       ser_in = 1'b0;
  logic [9:0] out_en;
  logic       clk_sel;
  int         checks = 0;
  int         failures = 0;
  bit         done = 1'b0;

  serial_cfg_loader u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .ser_in(ser_in),
    .out_en(out_en), .clk_sel(clk_sel)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [10:0] exp);
    logic [10:0] act;
    act = {clk_sel, out_en};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%03h expected=%03h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic en, input logic si);
    @(negedge clk);
    cfg_en = en;
    ser_in = si;
    @(posedge clk);
    #1;
  endtask

  // Expected outputs once loaded: bit n (sent n-th) enables output 9-n, bit 10 is select.
  function automatic logic [10:0] expect_loaded(input logic [10:0] pat);
    logic [10:0] e;
    for (int j = 0; j < 10; j++) e[j] = pat[9 - j];
    e[10] = pat[10];
    return e;
  endfunction

  task automatic program_and_check(input logic [10:0] pat);
    step(1'b0, 1'b0);                                    // re-arm edge
    for (int n = 0; n < 11; n++) step(1'b1, pat[n]);
    chk("R2 no load after 11 shifts", 11'h000);
    step(1'b1, 1'b0);
    chk("R1 R5 loaded word", expect_loaded(pat));
    for (int k = 0; k < 3; k++) begin
      step(1'b1, k[0]);
      chk("R3 later edges ignored", expect_loaded(pat));
    end
    @(negedge clk);
    cfg_en = 1'b0;
    ser_in = ~pat[10];
    #1;
    chk("R6 bypass overrides stored word", {~pat[10], 10'h3FF});
    step(1'b0, 1'b1);
    @(negedge clk);
    cfg_en = 1'b1;
    #1;
    chk("R4 re-arm clears control", 11'h000);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R8 bypass during power-on clear", 11'h3FF);
    cfg_en = 1'b1;
    #1;
    chk("R8 state cleared during power-on clear", 11'h000);
    cfg_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R6 bypass select 0", 11'h3FF);
    ser_in = 1'b1;
    #1;
    chk("R6 bypass select 1", 11'h7FF);
    step(1'b0, 1'b0);
    @(negedge clk);
    cfg_en = 1'b1;
    #1;
    chk("R7 unloaded state", 11'h000);

    for (int b = 0; b < 11; b++) program_and_check(11'(1) << b);
    program_and_check(11'h7FF);
    program_and_check(11'h555);
    program_and_check(11'h2AA);
    program_and_check(11'h000);
    program_and_check(11'h4A3);

    // R4: a partial sequence interrupted by re-arm leaves no trace
    step(1'b0, 1'b0);
    for (int n = 0; n < 5; n++) step(1'b1, 1'b1);
    chk("R7 partial shift not visible", 11'h000);
    program_and_check(11'h155);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule